// File: doc/BRIEF.md
# Scrambled-Table ROM Bank Controller

This block sits between a CPU bus and a 512 KB cartridge ROM split into 32 banks of 16 KB. The lower 16 KB CPU window always shows bank 0. The upper 16 KB window shows a switchable bank. That bank is not the value the CPU writes. The written value is used as an index into a fixed 32-entry lookup table, and the table's answer is the bank. A mode flag, when it is set, permutes the looked-up value once more before it is stored.

The bank is captured only when a bank write occurs. A later change of the mode flag leaves the stored bank as it is. An 8 KB cartridge RAM is passed straight through with no banking and no enable. When no RAM is fitted, reads of its window return 0xFF.

Top module: `scramble_bank_ctl`

## Requirements
- R1: A read anywhere in 0x0000-0x3FFF presents ROM address {5'd0, addr[13:0]}, so it always reads bank 0.
- R2: A read in 0x4000-0x7FFF presents ROM address {bank, addr[13:0]}, where bank is the 5-bit latched switchable bank. The ROM byte is returned on cpu_rdata in the same cycle.
- R3: A write to 0x2000-0x2FFF takes data[4:0] as an index and latches the matching table value. The table, in hex, for index 0 up to 31 is: 00 04 01 05 02 06 03 05 08 0C 03 0D 03 0B 0B 08 05 06 0B 0D 08 06 13 0B 08 05 05 08 0B 0D 06 05. The new bank is visible from the next cycle.
- R4: A write to 0x5000-0x5FFF loads the mode flag from data bit 5. The other data bits are ignored.
- R5: While the mode flag is 1, a bank write remaps the table value as follows: 02 becomes 04, 03 becomes 06, 04 becomes 02, 05 becomes 03, 06 becomes 05, 0B becomes 0D, 0C becomes 0B, and 0D becomes 0C. Every other value, 00, 01, 08, 0F and 13 among them, is kept as it is.
- R6: Writing the mode flag does not alter the bank already latched.
- R7: Writes to 0x0000-0x1FFF, 0x3000-0x4FFF and 0x6000-0x7FFF change neither the bank nor the mode flag.
- R8: Accesses to 0xA000-0xBFFF go to the RAM at ram_addr = addr[12:0] with no banking. A read returns ram_rdata. A write drives ram_we with ram_wdata = cpu_wdata.
- R9: When ram_present is 0, reads of 0xA000-0xBFFF return 0xFF and ram_we stays low.
- R10: After reset the mode flag is 0 and the switchable bank is 1.
- R11: cpu_rdata is 0xFF when cpu_rd is low or when the address is outside both the ROM windows and the RAM window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, sampled at the clock edge |
| cpu_rdata | output | 8 | Read data back to the CPU |
| rom_addr | output | 19 | ROM byte address |
| rom_rdata | input | 8 | ROM data |
| ram_present | input | 1 | Cartridge RAM fitted |
| ram_addr | output | 13 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data |

## Verification
Every one of the 32 table indices is written with the mode flag clear and then again with it set. Each bank write carries garbage in data bits 7:5, and each is followed by a read of the upper window. Comparing the two sweeps shows which values are remapped and which pass through unchanged.

Mode writes are placed between bank writes, both with bit 5 set and with every other bit set. This separates capture at write time from a live translation, and it shows that only bit 5 matters. Writes at the edges of every ignored range sit next to the 0x2FFF and 0x3000 boundaries of the bank-write range. RAM traffic is run with the RAM fitted and with it absent.

// File: rtl/scramble_bank_ctl.sv
module scramble_bank_ctl #(
  parameter int ROM_BANKS = 32,
  parameter int BANK_SZ   = 16384,
  parameter int RAM_AW    = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [7:0]        cpu_rdata,
  output logic [$clog2(ROM_BANKS*BANK_SZ)-1:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  input  logic              ram_present,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ram_we,
  input  logic [7:0]        ram_rdata
);
  localparam int BANK_W = $clog2(ROM_BANKS);
  localparam int OFS_W  = $clog2(BANK_SZ);

  logic [BANK_W-1:0] bank_q;
  logic              mode_q;
  logic [7:0]        looked, remapped;

  wire in_rom_lo = cpu_addr[15:14] == 2'b00;
  wire in_rom_hi = cpu_addr[15:14] == 2'b01;
  wire in_ram    = cpu_addr[15:13] == 3'b101;
  wire wr_bank   = cpu_wr && cpu_addr[15:12] == 4'h2;
  wire wr_mode   = cpu_wr && cpu_addr[15:12] == 4'h5;

  always_comb begin
    case (cpu_wdata[4:0])
      5'd0:  looked = 8'h00;  5'd1:  looked = 8'h04;
      5'd2:  looked = 8'h01;  5'd3:  looked = 8'h05;
      5'd4:  looked = 8'h02;  5'd5:  looked = 8'h06;
      5'd6:  looked = 8'h03;  5'd7:  looked = 8'h05;
      5'd8:  looked = 8'h08;  5'd9:  looked = 8'h0C;
      5'd10: looked = 8'h03;  5'd11: looked = 8'h0D;
      5'd12: looked = 8'h03;  5'd13: looked = 8'h0B;
      5'd14: looked = 8'h0B;  5'd15: looked = 8'h08;
      5'd16: looked = 8'h05;  5'd17: looked = 8'h06;
      5'd18: looked = 8'h0B;  5'd19: looked = 8'h0D;
      5'd20: looked = 8'h08;  5'd21: looked = 8'h06;
      5'd22: looked = 8'h13;  5'd23: looked = 8'h0B;
      5'd24: looked = 8'h08;  5'd25: looked = 8'h05;
      5'd26: looked = 8'h05;  5'd27: looked = 8'h08;
      5'd28: looked = 8'h0B;  5'd29: looked = 8'h0D;
      5'd30: looked = 8'h06;  default: looked = 8'h05;
    endcase
  end

  always_comb begin
    remapped = looked;
    if (mode_q) begin
      case (looked)
        8'h02: remapped = 8'h04;
        8'h03: remapped = 8'h06;
        8'h04: remapped = 8'h02;
        8'h05: remapped = 8'h03;
        8'h06: remapped = 8'h05;
        8'h0B: remapped = 8'h0D;
        8'h0C: remapped = 8'h0B;
        8'h0D: remapped = 8'h0C;
        default: remapped = looked;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= BANK_W'(1);
      mode_q <= 1'b0;
    end else begin
      if (wr_bank) bank_q <= remapped[BANK_W-1:0];
      if (wr_mode) mode_q <= cpu_wdata[5];
    end
  end

  assign rom_addr  = {(in_rom_hi ? bank_q : BANK_W'(0)), cpu_addr[OFS_W-1:0]};
  assign ram_addr  = cpu_addr[RAM_AW-1:0];
  assign ram_wdata = cpu_wdata;
  assign ram_we    = cpu_wr && in_ram && ram_present;
  assign cpu_rdata = !cpu_rd                  ? 8'hFF :
                     (in_rom_lo || in_rom_hi) ? rom_rdata :
                     (in_ram && ram_present)  ? ram_rdata : 8'hFF;

  AST_LOW_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_rom_lo |-> rom_addr[OFS_W +: BANK_W] == '0); // R1
  AST_MODE_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !wr_bank) |=> $stable(bank_q)); // R6
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15] == 1'b0 && !wr_bank && !wr_mode) |=> ($stable(bank_q) && $stable(mode_q))); // R7
  AST_NO_RAM_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram && !ram_present && cpu_rd) |-> (cpu_rdata == 8'hFF && !ram_we)); // R9
  AST_IDLE_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> cpu_rdata == 8'hFF); // R11
endmodule

// File: tb/test_scramble_bank_ctl.sv
module test_scramble_bank_ctl;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0, cpu_rdata, rom_rdata, ram_rdata, ram_wdata;
  logic cpu_rd = 0, cpu_wr = 0, ram_present = 1, ram_we;
  logic [18:0] rom_addr;
  logic [12:0] ram_addr;
  int n_tests = 0, n_fail = 0;
  int m_bank = 1, m_mode = 0;
  bit done = 0;
  byte unsigned tbl[32] = '{8'h00,8'h04,8'h01,8'h05,8'h02,8'h06,8'h03,8'h05,
                            8'h08,8'h0C,8'h03,8'h0D,8'h03,8'h0B,8'h0B,8'h08,
                            8'h05,8'h06,8'h0B,8'h0D,8'h08,8'h06,8'h13,8'h0B,
                            8'h08,8'h05,8'h05,8'h08,8'h0B,8'h0D,8'h06,8'h05};

  always #4 clk = ~clk;
  assign rom_rdata = rom_addr[18:11] ^ rom_addr[7:0];
  assign ram_rdata = ram_addr[7:0] ^ 8'h5A;

  scramble_bank_ctl i_scramble_bank_ctl (.*);

  function automatic int xl(int idx, int mode);
    int v = tbl[idx];
    if (mode != 0)
      case (v)
        2: v = 4;  3: v = 6;  4: v = 2;  5: v = 3;  6: v = 5;
        11: v = 13; 12: v = 11; 13: v = 12;
        default: ;
      endcase
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic acc(logic [15:0] a, logic [7:0] d, bit wr, bit rd, string req);
    int exp_ra, exp_rd;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = wr; cpu_rd = rd;
    #1;
    exp_ra = (a < 16'h4000) ? int'(a) : (m_bank * 16384 + int'(a[13:0]));
    if (a < 16'h8000) chk(req, int'(rom_addr), exp_ra);
    if (!rd) exp_rd = 8'hFF;
    else if (a < 16'h8000) exp_rd = exp_ra[18:11] ^ exp_ra[7:0];
    else if (a[15:13] == 3'b101 && ram_present) exp_rd = a[7:0] ^ 8'h5A;
    else exp_rd = 8'hFF;
    chk(req, int'(cpu_rdata), exp_rd);
    if (a[15:13] == 3'b101) begin
      chk(req, int'(ram_we), (wr && ram_present) ? 1 : 0);
      if (ram_present) chk(req, int'(ram_addr), int'(a[12:0]));
      if (wr && ram_present) chk(req, int'(ram_wdata), int'(d));
    end else chk(req, int'(ram_we), 0);
    if (wr && a[15:12] == 4'h2) m_bank = xl(int'(d[4:0]), m_mode);
    if (wr && a[15:12] == 4'h5) m_mode = int'(d[5]);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    acc(16'h4000, 0, 0, 1, "R10");
    acc(16'h7FFF, 0, 0, 1, "R10");
    acc(16'h0000, 0, 0, 1, "R1");
    acc(16'h3FFF, 0, 0, 1, "R1");
    acc(16'h1234, 0, 0, 0, "R11");
    for (int i = 0; i < 32; i++) begin
      acc(16'h2000 + 16'(i * 127 % 4096), 8'(i | ((i * 3) << 5)), 1, 0, "R3");
      acc(16'h4000 + 16'(i * 511), 0, 0, 1, "R3 R2");
      acc(16'h0100 + 16'(i), 0, 0, 1, "R1");
    end
    acc(16'h2FFF, 8'h16, 1, 0, "R3");
    acc(16'h5000, 8'h20, 1, 0, "R4");
    acc(16'h4ABC, 0, 0, 1, "R6");
    for (int i = 0; i < 32; i++) begin
      acc(16'h2000 + 16'(i * 61 % 4096), 8'(i | 8'hE0), 1, 0, "R5");
      acc(16'h6000 + 16'(i * 256), 0, 0, 1, "R5 R2");
    end
    acc(16'h2000, 8'h04, 1, 0, "R5");
    acc(16'h5FFF, 8'hDF, 1, 0, "R4");
    acc(16'h5000, 8'h00, 1, 0, "R6");
    acc(16'h4000, 0, 0, 1, "R6");
    acc(16'h2000, 8'h04, 1, 0, "R4");
    acc(16'h4001, 0, 0, 1, "R4");
    acc(16'h5800, 8'h20, 1, 0, "R4");
    acc(16'h0000, 8'h0A, 1, 0, "R7");
    acc(16'h1FFF, 8'h03, 1, 0, "R7");
    acc(16'h3000, 8'h05, 1, 0, "R7");
    acc(16'h4FFF, 8'h20, 1, 0, "R7");
    acc(16'h6000, 8'h00, 1, 0, "R7");
    acc(16'h7FFF, 8'hFF, 1, 0, "R7");
    acc(16'h4321, 0, 0, 1, "R7");
    acc(16'h2000, 8'h02, 1, 0, "R7");
    acc(16'h4321, 0, 0, 1, "R7");
    acc(16'hA000, 8'h77, 1, 0, "R8");
    acc(16'hBFFF, 8'h11, 1, 1, "R8");
    acc(16'hA5A5, 0, 0, 1, "R8");
    acc(16'hC000, 0, 0, 1, "R11");
    acc(16'h8000, 0, 0, 1, "R11");
    ram_present = 0;
    acc(16'hA000, 8'h33, 1, 0, "R9");
    acc(16'hB123, 0, 0, 1, "R9");
    acc(16'hA001, 0, 0, 0, "R11");
    ram_present = 1;
    acc(16'hA001, 0, 0, 1, "R8");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule